// File: doc/BRIEF.md
# Paged DMA Address and Count Generator

This block is the transfer datapath of one channel of an ISA-style DMA controller. Software programs a 16-bit start address, a 16-bit transfer count, an 8-bit page value and the channel width (byte or word). It may also program a high-page value. The block then presents the physical bus address of the current transfer. On every accepted transfer it moves to the next unit and counts down. When the last transfer is done it signals terminal count.

Byte channels address memory in bytes, inside 64K pages. Word channels address memory in 16-bit units, inside 128K pages. For a word channel the address is shifted up by one and the lowest page bit is not used. The low address normally wraps inside its page. Writing the high-page value supplies address bits [31:24] and lets the increment carry into the page and high-page values.

The transfer strobe is a valid/ready handshake. A transfer is taken on a rising clock edge where `xfer_valid` and `xfer_ready` are both high and `prog_load` is low. `xfer_ready` is low while the channel is masked. While ready is low, `xfer_valid` may stay high and has no effect. A `prog_load` in the same cycle as a handshake discards that transfer. The programming inputs and the outputs are plain signals.

Top module: `dma_page_addr_gen`

## Requirements
- R1: On a byte channel, `bus_addr[23:16]` equals the page value and `bus_addr[15:0]` equals the 16-bit current address.
- R2: On a word channel, `bus_addr[0]` is 0, `bus_addr[16:1]` equals the current address, `bus_addr[23:17]` equals page bits [7:1], and page bit 0 has no effect on the output.
- R3: Unless the high-page value has been written since the last load, stepping the current address from 0xFFFF wraps it to 0x0000 and leaves the page value unchanged.
- R4: `bus_addr[31:24]` shows the high-page value. A load clears it and `hip_we` writes it. After a `hip_we`, an address carry out of 0xFFFF adds one page unit (1 on byte channels, 2 on word channels), and a carry out of the page adds 1 to the high-page value.
- R5: Each accepted transfer raises the current address by one and lowers the current count by one, both modulo 2^16.
- R6: The count holds the number of transfers minus one, so a loaded count of N-1 gives exactly N transfers. `tc_pulse` is high for the one cycle after the edge that accepted the transfer which moved the count from 0x0000 to 0xFFFF.
- R7: `residue` equals (current count + 1) modulo 2^16, shifted left by one on word channels. It is 0 after the last transfer, and 0 after loading a count of 0xFFFF.
- R8: With `prog_autoinit` set at load, the transfer that reaches terminal count restores the current address, count, page and high-page value to their programmed values, and `xfer_ready` stays high.
- R9: Without auto-initialise, `xfer_ready` falls after terminal count and stays low until the next `prog_load`. A `xfer_valid` while ready is low changes nothing.
- R10: `prog_load` takes priority over a transfer in the same cycle. The load takes effect and the transfer is discarded.
- R11: After reset, `bus_addr` is 0, `residue` is 0, `tc_pulse` is 0 and `xfer_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_load | input | 1 | Load the programmed address, count, page and mode |
| prog_addr | input | 16 | Start address in transfer units |
| prog_count | input | 16 | Number of transfers minus one |
| prog_page | input | 8 | Page value |
| prog_word | input | 1 | 1 selects a word channel, 0 a byte channel |
| prog_autoinit | input | 1 | Restore the programmed values at terminal count |
| hip_we | input | 1 | Write the high-page value and enable carry across pages |
| hip_data | input | 8 | High-page value, becomes address bits [31:24] |
| xfer_valid | input | 1 | Transfer acknowledge offered |
| xfer_ready | output | 1 | Channel unmasked and able to take a transfer |
| bus_addr | output | 32 | Physical address of the current transfer |
| tc_pulse | output | 1 | One-cycle terminal count indication |
| residue | output | 17 | Remaining bytes (byte channel) or bytes as words times two |

## Verification
Two pairs of events can fall in the same cycle. The first is a load together with a transfer handshake: the bench drives `prog_load` and `xfer_valid` on the same edge, once on a channel in mid-transfer. It then expects the freshly loaded address and residue, as if the transfer had never been offered. The second is terminal count together with a high-page write or an auto-initialise reload. The behavioural model gives the write and the load priority, and its output is compared with the design's address, residue, ready and terminal-count outputs after every clock.

// File: rtl/dpag_pkg.sv
package dpag_pkg;

  // Channel mode captured at load time.
  typedef struct packed {
    logic word;      // 1: 16-bit transfer units, 128K pages
    logic autoinit;  // 1: restore programmed values at terminal count
  } dpag_cfg_t;

  localparam dpag_cfg_t DPAG_CFG_RESET = '{word: 1'b0, autoinit: 1'b0};

endpackage

// File: rtl/dpag_count.sv
module dpag_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  input  logic          autoinit,
  output logic [CW-1:0] cnt,
  output logic          underflow
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] base_q;

  assign underflow = step && (cnt_q == '0);
  assign cnt       = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      base_q <= '1;
    end else if (load) begin
      cnt_q  <= load_val;
      base_q <= load_val;
    end else if (step) begin
      if (underflow && autoinit) cnt_q <= base_q;
      else                       cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5: count falls by one per accepted transfer
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q != '0) |=> cnt_q == CW'($past(cnt_q) - 1'b1));

  // R8: auto-initialise restores the programmed count
  p_count_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q == '0 && autoinit) |=> cnt_q == base_q);

endmodule

// File: rtl/dpag_addr_ctr.sv
module dpag_addr_ctr #(
  parameter int AW = 16,
  parameter int PW = 8,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [PW-1:0] ld_page,
  input  logic          hip_we,
  input  logic [HW-1:0] hip_in,
  input  logic          step,
  input  logic          reload,
  input  logic          word,
  output logic [AW-1:0] cur,
  output logic [PW-1:0] page,
  output logic [HW-1:0] hip
);

  logic [AW-1:0] cur_q, base_addr_q;
  logic [PW-1:0] page_q, base_page_q;
  logic [HW-1:0] hip_q, base_hip_q;
  logic          ext_q;

  logic [AW-1:0] cur_inc;
  logic          addr_carry;
  logic [PW-1:0] page_inc;
  logic          page_carry;
  logic [PW-1:0] page_unit;

  assign page_unit               = word ? PW'(2) : PW'(1);
  assign {addr_carry, cur_inc}   = {1'b0, cur_q} + 1'b1;
  assign {page_carry, page_inc}  = {1'b0, page_q} + {1'b0, page_unit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q       <= '0;
      page_q      <= '0;
      hip_q       <= '0;
      base_addr_q <= '0;
      base_page_q <= '0;
      base_hip_q  <= '0;
      ext_q       <= 1'b0;
    end else if (load) begin
      cur_q       <= ld_addr;
      page_q      <= ld_page;
      base_addr_q <= ld_addr;
      base_page_q <= ld_page;
      hip_q       <= hip_we ? hip_in : '0;
      base_hip_q  <= hip_we ? hip_in : '0;
      ext_q       <= hip_we;
    end else begin
      if (step) begin
        if (reload) begin
          cur_q  <= base_addr_q;
          page_q <= base_page_q;
          hip_q  <= base_hip_q;
        end else begin
          cur_q <= cur_inc;
          if (ext_q && addr_carry) page_q <= page_inc;
          if (ext_q && addr_carry && page_carry) hip_q <= hip_q + 1'b1;
        end
      end
      if (hip_we) begin
        hip_q      <= hip_in;
        base_hip_q <= hip_in;
        ext_q      <= 1'b1;
      end
    end
  end

  assign cur  = cur_q;
  assign page = page_q;
  assign hip  = hip_q;

  // R3: without the high-page write the page never moves on a step
  p_page_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ext_q && !load && !reload) |=> $stable(page_q));

  // R4: byte channel carry out of the last page bumps the high page
  p_hip_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ext_q && !load && !reload && !hip_we && !word &&
     cur_q == '1 && page_q == '1) |=> hip_q == HW'($past(hip_q) + 1'b1));

endmodule

// File: rtl/dpag_map.sv
module dpag_map #(
  parameter int AW = 16,
  parameter int PW = 8,
  parameter int HW = 8,
  localparam int BW = HW + PW + AW
) (
  input  logic          word,
  input  logic [AW-1:0] cur,
  input  logic [PW-1:0] page,
  input  logic [HW-1:0] hip,
  input  logic [AW-1:0] cnt,
  output logic [BW-1:0] bus_addr,
  output logic [AW:0]   residue
);

  logic [AW-1:0] units_left;

  assign units_left = cnt + 1'b1;

  always_comb begin
    if (word) begin
      bus_addr = {hip, page[PW-1:1], cur, 1'b0};
      residue  = {units_left, 1'b0};
    end else begin
      bus_addr = {hip, page, cur};
      residue  = {1'b0, units_left};
    end
  end

endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen #(
  parameter int AW = 16,
  parameter int PW = 8,
  parameter int HW = 8,
  localparam int BW = HW + PW + AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_load,
  input  logic [AW-1:0] prog_addr,
  input  logic [AW-1:0] prog_count,
  input  logic [PW-1:0] prog_page,
  input  logic          prog_word,
  input  logic          prog_autoinit,
  input  logic          hip_we,
  input  logic [HW-1:0] hip_data,
  input  logic          xfer_valid,
  output logic          xfer_ready,
  output logic [BW-1:0] bus_addr,
  output logic          tc_pulse,
  output logic [AW:0]   residue
);
  import dpag_pkg::*;

  dpag_cfg_t     cfg_q;
  logic          masked_q;
  logic          tc_q;
  logic          accept;
  logic          underflow;
  logic          reload;
  logic [AW-1:0] cnt;
  logic [AW-1:0] cur;
  logic [PW-1:0] page;
  logic [HW-1:0] hip;

  assign xfer_ready = !masked_q;
  assign accept     = xfer_valid && xfer_ready && !prog_load;
  assign reload     = underflow && cfg_q.autoinit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= DPAG_CFG_RESET;
      masked_q <= 1'b1;
      tc_q     <= 1'b0;
    end else begin
      tc_q <= underflow;
      if (prog_load) begin
        cfg_q    <= '{word: prog_word, autoinit: prog_autoinit};
        masked_q <= 1'b0;
      end else if (underflow && !cfg_q.autoinit) begin
        masked_q <= 1'b1;
      end
    end
  end

  dpag_count #(.CW(AW)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (prog_load),
    .load_val  (prog_count),
    .step      (accept),
    .autoinit  (cfg_q.autoinit),
    .cnt       (cnt),
    .underflow (underflow)
  );

  dpag_addr_ctr #(.AW(AW), .PW(PW), .HW(HW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (prog_load),
    .ld_addr (prog_addr),
    .ld_page (prog_page),
    .hip_we  (hip_we),
    .hip_in  (hip_data),
    .step    (accept),
    .reload  (reload),
    .word    (cfg_q.word),
    .cur     (cur),
    .page    (page),
    .hip     (hip)
  );

  dpag_map #(.AW(AW), .PW(PW), .HW(HW)) u_map (
    .word     (cfg_q.word),
    .cur      (cur),
    .page     (page),
    .hip      (hip),
    .cnt      (cnt),
    .bus_addr (bus_addr),
    .residue  (residue)
  );

  assign tc_pulse = tc_q;

  // R6: terminal count only follows an accepted transfer
  p_tc_after_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> $past(accept));

  // R7: a finished, non-repeating channel has nothing left
  p_residue_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && !cfg_q.autoinit) |-> residue == '0);

  // R9: the channel is masked after a non-repeating terminal count
  p_mask_after_tc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && !cfg_q.autoinit) |-> !xfer_ready);

  // R9: only a load unmasks the channel
  p_mask_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_ready && !prog_load) |=> !xfer_ready);

endmodule

// File: tb/test_dma_page_addr_gen.sv
module test_dma_page_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_load = 1'b0;
  logic [15:0] prog_addr = '0;
  logic [15:0] prog_count = '0;
  logic [7:0]  prog_page = '0;
  logic        prog_word = 1'b0;
  logic        prog_autoinit = 1'b0;
  logic        hip_we = 1'b0;
  logic [7:0]  hip_data = '0;
  logic        xfer_valid = 1'b0;
  logic        xfer_ready;
  logic [31:0] bus_addr;
  logic        tc_pulse;
  logic [16:0] residue;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_page_addr_gen i_dma_page_addr_gen (
    .clk (clk), .rst_n (rst_n), .prog_load (prog_load), .prog_addr (prog_addr),
    .prog_count (prog_count), .prog_page (prog_page), .prog_word (prog_word),
    .prog_autoinit (prog_autoinit), .hip_we (hip_we), .hip_data (hip_data),
    .xfer_valid (xfer_valid), .xfer_ready (xfer_ready), .bus_addr (bus_addr),
    .tc_pulse (tc_pulse), .residue (residue)
  );

  // Behavioural reference state
  int m_cur, m_page, m_hip, m_cnt, m_ext, m_word, m_ai, m_masked, m_tc;
  int b_cur, b_page, b_hip, b_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cur = 0; m_page = 0; m_hip = 0; m_cnt = 'hFFFF; m_ext = 0;
      m_word = 0; m_ai = 0; m_masked = 1; m_tc = 0;
      b_cur = 0; b_page = 0; b_hip = 0; b_cnt = 'hFFFF;
    end else begin
      m_tc = 0;
      if (prog_load) begin
        m_cur = prog_addr; m_page = prog_page; m_cnt = prog_count;
        b_cur = prog_addr; b_page = prog_page; b_cnt = prog_count;
        m_hip = hip_we ? hip_data : 0; b_hip = m_hip; m_ext = hip_we;
        m_word = prog_word; m_ai = prog_autoinit; m_masked = 0;
      end else begin
        if (xfer_valid && !m_masked) begin
          if (m_cnt == 0) m_tc = 1;
          m_cnt = (m_cnt + 'hFFFF) % 'h10000;
          if (m_tc && m_ai) begin
            m_cur = b_cur; m_page = b_page; m_hip = b_hip; m_cnt = b_cnt;
          end else begin
            if (m_tc) m_masked = 1;
            m_cur = m_cur + 1;
            if (m_cur > 'hFFFF) begin
              m_cur = 0;
              if (m_ext != 0) begin
                m_page = m_page + (m_word != 0 ? 2 : 1);
                if (m_page > 255) begin
                  m_page = m_page - 256;
                  m_hip = (m_hip + 1) % 256;
                end
              end
            end
          end
        end
        if (hip_we) begin
          m_hip = hip_data; b_hip = hip_data; m_ext = 1;
        end
      end
    end
  end

  function automatic logic [31:0] exp_addr();
    if (m_word != 0) return {m_hip[7:0], m_page[7:1], m_cur[15:0], 1'b0};
    return {m_hip[7:0], m_page[7:0], m_cur[15:0]};
  endfunction

  function automatic logic [16:0] exp_res();
    logic [15:0] u;
    u = 16'((m_cnt + 1) % 'h10000);
    return (m_word != 0) ? {u, 1'b0} : {1'b0, u};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk((m_word != 0) ? "R2 addr" : "R1 addr", bus_addr, exp_addr());
    chk("R7 residue", 32'(residue), 32'(exp_res()));
    chk("R6 tc", 32'(tc_pulse), 32'(m_tc));
    chk("R9 ready", 32'(xfer_ready), 32'(m_masked == 0));
  endtask

  // One cycle: drive inputs, let the edge pass, compare at the falling edge.
  task automatic cyc(bit ld, bit v, bit hw, logic [7:0] hd);
    prog_load = ld; xfer_valid = v; hip_we = hw; hip_data = hd;
    @(negedge clk);
    compare_all();
    prog_load = 0; xfer_valid = 0; hip_we = 0;
  endtask

  task automatic setup(logic [15:0] a, logic [15:0] c, logic [7:0] p, bit w, bit ai);
    prog_addr = a; prog_count = c; prog_page = p; prog_word = w; prog_autoinit = ai;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 addr", bus_addr, 32'h0);
    chk("R11 residue", 32'(residue), 32'h0);
    chk("R11 tc", 32'(tc_pulse), 32'h0);
    chk("R11 ready", 32'(xfer_ready), 32'h0);
    rst_n = 1;
    @(negedge clk);
    compare_all();

    // R1 R3 R5 R6 R9: byte channel wrapping inside its page
    setup(16'hFFFE, 16'd3, 8'h12, 0, 0);
    cyc(1, 0, 0, 0);
    chk("R1 map", bus_addr, 32'h0012FFFE);
    chk("R7 initial", 32'(residue), 32'd4);
    cyc(0, 1, 0, 0);
    chk("R5 step", bus_addr, 32'h0012FFFF);
    cyc(0, 1, 0, 0);
    chk("R3 wrap", bus_addr, 32'h00120000);
    cyc(0, 0, 0, 0);
    cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 0);
    chk("R6 tc", 32'(tc_pulse), 32'h1);
    chk("R7 done", 32'(residue), 32'h0);
    chk("R9 masked", 32'(xfer_ready), 32'h0);
    cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 0);
    chk("R9 ignored", bus_addr, 32'h00120002);
    chk("R6 single pulse", 32'(tc_pulse), 32'h0);

    // R2 R8: word channel with auto-initialise
    setup(16'h8000, 16'd1, 8'h35, 1, 1);
    cyc(1, 0, 0, 0);
    chk("R2 map", bus_addr, 32'h00350000);
    chk("R7 word", 32'(residue), 32'd4);
    cyc(0, 1, 0, 0);
    chk("R2 step", bus_addr, 32'h00350002);
    cyc(0, 1, 0, 0);
    chk("R8 reload addr", bus_addr, 32'h00350000);
    chk("R8 ready", 32'(xfer_ready), 32'h1);
    chk("R8 tc", 32'(tc_pulse), 32'h1);
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0);

    // R4: byte carry through page into high page
    setup(16'hFFFF, 16'd2, 8'hFF, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 8'h7A);
    chk("R4 hip", bus_addr, 32'h7AFFFFFF);
    cyc(0, 1, 0, 0);
    chk("R4 carry", bus_addr, 32'h7B000000);

    // R4: word carry adds two to the page
    setup(16'hFFFF, 16'd5, 8'h04, 1, 0);
    cyc(1, 0, 1, 8'h01);
    chk("R4 word map", bus_addr, 32'h0105FFFE);
    cyc(0, 1, 0, 0);
    chk("R4 word carry", bus_addr, 32'h01060000);

    // R10: load together with a transfer
    cyc(0, 1, 0, 0);
    setup(16'h1000, 16'd0, 8'h00, 0, 0);
    cyc(1, 1, 0, 0);
    chk("R10 addr", bus_addr, 32'h00001000);
    chk("R10 residue", 32'(residue), 32'd1);
    cyc(0, 1, 0, 0);
    chk("R6 one transfer", 32'(tc_pulse), 32'h1);

    // R7: maximum count
    setup(16'h0000, 16'hFFFF, 8'h02, 0, 1);
    cyc(1, 0, 0, 0);
    chk("R7 full count", 32'(residue), 32'h0);
    cyc(0, 1, 0, 0);
    chk("R7 after one", 32'(residue), 32'hFFFF);

    // R8: terminal count coinciding with a high-page write
    setup(16'h0010, 16'd0, 8'h03, 0, 1);
    cyc(1, 0, 0, 0);
    cyc(0, 1, 1, 8'h44);
    chk("R8 with hip", bus_addr, 32'h44030010);
    for (int i = 0; i < 4; i++) cyc(0, i % 2, 0, 0);

    finish_up();
  end

endmodule